// File: doc/BRIEF.md
# Indexed Configuration Register Window

This block gives a host a byte-wide path into the configuration space of a disk-channel controller through just two I/O addresses. The host first writes an 8-bit register number to the window's index address, then reads or writes the selected register through the data address, which sits four bytes above it. A strap input picks one of two base addresses, so two devices can coexist or a probe can find the device at a known alternative location.

Behind the window sit a configuration byte, a control byte, six timing bytes, a mixed timing/status byte for the secondary channel, a read-ahead burst-size byte and a scratch byte. The block drives the settings held in these bytes out to the rest of the controller: a secondary-channel enable, a fast device-select indication, four per-drive read-ahead disables, the burst size and the raw timing bytes. It also reports live interrupt-pending status for both channels in fixed bit positions.

Host reads are registered. Read data appears on `rdata` one clock after the read strobe and holds until the next read. The scratch byte lets a probe write a pattern and read it back to confirm that the device is present.

Top module: `cfgwin_port`

## Requirements
- R1: The index address is 0x178 when `strap_alt`=0 and 0x078 when `strap_alt`=1. The data address is the index address + 4. A read of any other address returns 0x00 one cycle later, and a write to any other address changes nothing.
- R2: The index register resets to 0x00, and a read of the index address returns the last index written.
- R3: Register 0x50 reads as {bits7:6 writable (reset 00), bit5 = `strap_alt`, bits4:3 = DEV_ID (default 01), bit2 = `irq_pri`, bits1:0 = REV (default 10, never 0)}. Writes change only bits 7:6.
- R4: Register 0x51 is fully writable and resets to 0x00. Its bit 3 drives `sec_chan_en`, bit 6 drives `ra_disable[0]` and bit 7 drives `ra_disable[1]`.
- R5: `fast_devsel` is 1 only when bits 0, 1, 2 and 5 of register 0x51 (mask 0x27) are all 1.
- R6: Register 0x57 resets to 0x00. Bit 4 reads the live `irq_sec` input and ignores writes. Bits 2 and 3 drive `ra_disable[2]` and `ra_disable[3]`. The other bits are writable.
- R7: Register 0x59 resets to 0x40 (512-byte burst), is fully writable and drives `burst_sel`.
- R8: Register 0x5B is a scratch byte that resets to 0x00 and returns exactly the value last written.
- R9: Registers 0x52, 0x53, 0x54, 0x55, 0x56 and 0x58 are fully writable, reset to 0x00, and appear on `timing_bytes` in that order, from bits 7:0 upward.
- R10: Indices without a register read as 0x00 and ignore writes.
- R11: `rdata` is loaded on the clock edge at which `rd_en` is sampled and holds its value while no read occurs. A read in the same cycle as a write returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Host I/O address |
| wr_en | input | 1 | Host write strobe, one cycle per byte |
| rd_en | input | 1 | Host read strobe, one cycle per byte |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered read data |
| strap_alt | input | 1 | Base-address strap (1 selects the low base) |
| irq_pri | input | 1 | Primary-channel interrupt pending |
| irq_sec | input | 1 | Secondary-channel interrupt pending |
| sec_chan_en | output | 1 | Secondary channel enable |
| fast_devsel | output | 1 | Fast device-select enabled |
| ra_disable | output | 4 | Per-drive read-ahead disable, drives 0..3 |
| burst_sel | output | 8 | Read-ahead burst-size code |
| timing_bytes | output | 48 | Six timing bytes, packed |

## Verification
The host can write the secondary timing/status byte in the same cycle that `irq_sec` is active. The bench provokes this by raising `irq_sec` for exactly the write cycle, writing 0xFF, dropping the interrupt and then reading the byte back. The read must return 0xEF: every writable bit is kept, but the status position shows the current input rather than anything the write stored. A second read with the interrupt raised again must show 0xFF, which confirms that the bit follows the input.

// File: rtl/cfgwin_pkg.sv
// Package: shared register numbers and constants for the configuration window.
// Assumes an 8-bit index space; the map below is fixed by the controller.
package cfgwin_pkg;

    localparam int DATA_W = 8;
    localparam int NUM_TIM = 6;

    localparam logic [7:0] IX_CFG     = 8'h50;
    localparam logic [7:0] IX_CTRL    = 8'h51;
    localparam logic [7:0] IX_SEC_TIM = 8'h57;
    localparam logic [7:0] IX_BURST   = 8'h59;
    localparam logic [7:0] IX_SCRATCH = 8'h5B;

    localparam logic [7:0] DEVSEL_MASK = 8'h27;
    localparam logic [7:0] BURST_RST   = 8'h40;
    localparam logic [7:0] SEC_IRQ_BIT = 8'h10;

    // Register number of timing slot s: 0x52..0x56, then 0x58.
    function automatic logic [7:0] tim_index(input int s);
        logic [7:0] s8;
        s8 = s[7:0];
        return (s < 5) ? (8'h52 + s8) : 8'h58;
    endfunction

endpackage

// File: rtl/cfgwin_decode.sv
// Module: cfgwin_decode
// Turns a host address and strobes into per-target strobes for the index and
// data locations. The base is chosen at run time by the strap input.
// Assumes the host drives at most one of wr_en/rd_en per cycle in normal use.
module cfgwin_decode #(
    parameter int ADDR_W   = 10,
    parameter int BASE_PRI = 'h178,
    parameter int BASE_ALT = 'h078,
    parameter int DATA_OFS = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic              strap_alt_i,
    output logic              idx_wr_o,
    output logic              idx_rd_o,
    output logic              dat_wr_o,
    output logic              dat_rd_o,
    output logic              rd_miss_o
);
    localparam logic [ADDR_W-1:0] PRI_IDX = BASE_PRI[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] ALT_IDX = BASE_ALT[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] PRI_DAT = PRI_IDX + DATA_OFS[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] ALT_DAT = ALT_IDX + DATA_OFS[ADDR_W-1:0];

    logic hit_idx;
    logic hit_dat;

    // Match the address against the strap-selected pair of locations.
    always_comb begin
        hit_idx = strap_alt_i ? (addr_i == ALT_IDX) : (addr_i == PRI_IDX);
        hit_dat = strap_alt_i ? (addr_i == ALT_DAT) : (addr_i == PRI_DAT);
    end

    // Qualify the strobes with the address match.
    always_comb begin
        idx_wr_o  = wr_i && hit_idx;
        idx_rd_o  = rd_i && hit_idx;
        dat_wr_o  = wr_i && hit_dat;
        dat_rd_o  = rd_i && hit_dat;
        rd_miss_o = rd_i && !hit_idx && !hit_dat;
    end

endmodule

// File: rtl/cfgwin_regs.sv
// Module: cfgwin_regs
// Holds the index register and every writable configuration byte.
// Read-only fields (revision, ID, strap, interrupt status) are not stored here;
// they are merged in by the read path. Writes to unmapped indices are dropped.
module cfgwin_regs
    import cfgwin_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  idx_wr_i,
    input  logic                  dat_wr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [7:0]            index_o,
    output logic [1:0]            cfg_rw_o,
    output logic [DATA_W-1:0]     ctrl_o,
    output logic [DATA_W-1:0]     sec_tim_o,
    output logic [DATA_W-1:0]     burst_o,
    output logic [DATA_W-1:0]     scratch_o,
    output logic [NUM_TIM*8-1:0]  timing_o
);
    logic [7:0]        index_q;
    logic [1:0]        cfg_rw_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] sec_tim_q;
    logic [DATA_W-1:0] burst_q;
    logic [DATA_W-1:0] scratch_q;

    // Index register: loaded by a write to the index location.
    always_ff @(posedge clk) begin
        if (!rst_n)        index_q <= '0;
        else if (idx_wr_i) index_q <= wdata_i;
    end

    // Configuration byte: only the top two bits are storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                              cfg_rw_q <= '0;
        else if (dat_wr_i && index_q == IX_CFG)  cfg_rw_q <= wdata_i[7:6];
    end

    // Control byte: fully writable.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ctrl_q <= '0;
        else if (dat_wr_i && index_q == IX_CTRL) ctrl_q <= wdata_i;
    end

    // Secondary timing/status byte: the interrupt bit position is never stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 sec_tim_q <= '0;
        else if (dat_wr_i && index_q == IX_SEC_TIM) sec_tim_q <= wdata_i & ~SEC_IRQ_BIT;
    end

    // Burst-size byte: resets to the 512-byte code.
    always_ff @(posedge clk) begin
        if (!rst_n)                               burst_q <= BURST_RST;
        else if (dat_wr_i && index_q == IX_BURST) burst_q <= wdata_i;
    end

    // Scratch byte: plain storage for presence probing.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 scratch_q <= '0;
        else if (dat_wr_i && index_q == IX_SCRATCH) scratch_q <= wdata_i;
    end

    // One storage byte per timing slot, each decoded from its own index.
    for (genvar s = 0; s < NUM_TIM; s++) begin : g_tim
        localparam logic [7:0] SLOT_IX = tim_index(s);
        logic [DATA_W-1:0] slot_q;

        // Timing slot storage.
        always_ff @(posedge clk) begin
            if (!rst_n)                              slot_q <= '0;
            else if (dat_wr_i && index_q == SLOT_IX) slot_q <= wdata_i;
        end

        assign timing_o[s*8 +: 8] = slot_q;
    end

    assign index_o   = index_q;
    assign cfg_rw_o  = cfg_rw_q;
    assign ctrl_o    = ctrl_q;
    assign sec_tim_o = sec_tim_q;
    assign burst_o   = burst_q;
    assign scratch_o = scratch_q;

    // R2: the index register takes the value written to the index location.
    a_r2_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr_i |=> index_q == $past(wdata_i));

    // R8: the scratch byte changes only on a write aimed at it.
    a_r8_scratch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(dat_wr_i && index_q == IX_SCRATCH) |=> $stable(scratch_q));

    // R6: the stored copy never carries the interrupt bit.
    a_r6_no_irq_store: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr_i && index_q == IX_SEC_TIM) |=> !sec_tim_q[4]);

endmodule

// File: rtl/cfgwin_rdmux.sv
// Module: cfgwin_rdmux
// Selects the byte addressed by the index, merges in live status and fixed
// identity fields, and registers it onto the host read data.
// Assumes identity parameters are constant; REV must be non-zero.
module cfgwin_rdmux
    import cfgwin_pkg::*;
#(
    parameter logic [1:0] REV    = 2'b10,
    parameter logic [1:0] DEV_ID = 2'b01
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  idx_rd_i,
    input  logic                  dat_rd_i,
    input  logic                  rd_miss_i,
    input  logic                  strap_alt_i,
    input  logic                  irq_pri_i,
    input  logic                  irq_sec_i,
    input  logic [7:0]            index_i,
    input  logic [1:0]            cfg_rw_i,
    input  logic [DATA_W-1:0]     ctrl_i,
    input  logic [DATA_W-1:0]     sec_tim_i,
    input  logic [DATA_W-1:0]     burst_i,
    input  logic [DATA_W-1:0]     scratch_i,
    input  logic [NUM_TIM*8-1:0]  timing_i,
    output logic [DATA_W-1:0]     rdata_o
);
    logic [DATA_W-1:0] sel_val;
    logic              sel_known;
    logic [DATA_W-1:0] rdata_q;

    // Pick the addressed byte; unknown indices give zero.
    always_comb begin
        sel_val   = '0;
        sel_known = 1'b1;
        case (index_i)
            IX_CFG:     sel_val = {cfg_rw_i, strap_alt_i, DEV_ID, irq_pri_i, REV};
            IX_CTRL:    sel_val = ctrl_i;
            IX_SEC_TIM: sel_val = {sec_tim_i[7:5], irq_sec_i, sec_tim_i[3:0]};
            IX_BURST:   sel_val = burst_i;
            IX_SCRATCH: sel_val = scratch_i;
            default: begin
                sel_known = 1'b0;
                for (int s = 0; s < NUM_TIM; s++) begin
                    if (index_i == tim_index(s)) begin
                        sel_val   = timing_i[s*8 +: 8];
                        sel_known = 1'b1;
                    end
                end
            end
        endcase
    end

    // Read data register: loaded only by a read strobe, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)         rdata_q <= '0;
        else if (idx_rd_i)  rdata_q <= index_i;
        else if (dat_rd_i)  rdata_q <= sel_val;
        else if (rd_miss_i) rdata_q <= '0;
    end

    assign rdata_o = rdata_q;

    // R10: a data read of an index with no register returns zero.
    a_r10_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd_i && !sel_known) |=> rdata_q == '0);

    // R1: reads outside the window return zero.
    a_r1_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_miss_i |=> rdata_q == '0);

    // R6: the secondary interrupt bit reflects the input at the read.
    a_r6_irq_live: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd_i && index_i == IX_SEC_TIM) |=> rdata_q[4] == $past(irq_sec_i));

    // R11: read data holds when no read strobe is accepted.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(idx_rd_i || dat_rd_i || rd_miss_i) |=> $stable(rdata_q));

endmodule

// File: rtl/cfgwin_port.sv
// Module: cfgwin_port (top)
// Two-address indexed configuration window: decoder, register storage and
// registered read path, plus the control outputs derived from stored bytes.
// Assumes a synchronous host and synchronous interrupt inputs.
module cfgwin_port
    import cfgwin_pkg::*;
#(
    parameter int         ADDR_W   = 10,
    parameter int         BASE_PRI = 'h178,
    parameter int         BASE_ALT = 'h078,
    parameter logic [1:0] REV      = 2'b10,
    parameter logic [1:0] DEV_ID   = 2'b01
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    input  logic                 strap_alt,
    input  logic                 irq_pri,
    input  logic                 irq_sec,
    output logic                 sec_chan_en,
    output logic                 fast_devsel,
    output logic [3:0]           ra_disable,
    output logic [7:0]           burst_sel,
    output logic [NUM_TIM*8-1:0] timing_bytes
);
    logic              idx_wr, idx_rd, dat_wr, dat_rd, rd_miss;
    logic [7:0]        index;
    logic [1:0]        cfg_rw;
    logic [DATA_W-1:0] ctrl, sec_tim, burst, scratch;

    cfgwin_decode #(
        .ADDR_W  (ADDR_W),
        .BASE_PRI(BASE_PRI),
        .BASE_ALT(BASE_ALT),
        .DATA_OFS(4)
    ) u_decode (
        .addr_i     (addr),
        .wr_i       (wr_en),
        .rd_i       (rd_en),
        .strap_alt_i(strap_alt),
        .idx_wr_o   (idx_wr),
        .idx_rd_o   (idx_rd),
        .dat_wr_o   (dat_wr),
        .dat_rd_o   (dat_rd),
        .rd_miss_o  (rd_miss)
    );

    cfgwin_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr_i (idx_wr),
        .dat_wr_i (dat_wr),
        .wdata_i  (wdata),
        .index_o  (index),
        .cfg_rw_o (cfg_rw),
        .ctrl_o   (ctrl),
        .sec_tim_o(sec_tim),
        .burst_o  (burst),
        .scratch_o(scratch),
        .timing_o (timing_bytes)
    );

    cfgwin_rdmux #(
        .REV   (REV),
        .DEV_ID(DEV_ID)
    ) u_rdmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_rd_i   (idx_rd),
        .dat_rd_i   (dat_rd),
        .rd_miss_i  (rd_miss),
        .strap_alt_i(strap_alt),
        .irq_pri_i  (irq_pri),
        .irq_sec_i  (irq_sec),
        .index_i    (index),
        .cfg_rw_i   (cfg_rw),
        .ctrl_i     (ctrl),
        .sec_tim_i  (sec_tim),
        .burst_i    (burst),
        .scratch_i  (scratch),
        .timing_i   (timing_bytes),
        .rdata_o    (rdata)
    );

    // Control outputs taken from stored control and timing/status bits.
    always_comb begin
        sec_chan_en = ctrl[3];
        fast_devsel = (ctrl & DEVSEL_MASK) == DEVSEL_MASK;
        ra_disable  = {sec_tim[3], sec_tim[2], ctrl[7], ctrl[6]};
        burst_sel   = burst;
    end

    // R5: a control write with every device-select bit set enables fast devsel.
    a_r5_devsel_on: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && index == IX_CTRL && (wdata & DEVSEL_MASK) == DEVSEL_MASK)
        |=> fast_devsel);

    // R4: secondary enable follows control bit 3 after a control write.
    a_r4_sec_en: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && index == IX_CTRL) |=> sec_chan_en == $past(wdata[3]));

endmodule

// File: tb/cfgwin_port_tb.sv
// Scoreboard bench: read tasks push expected bytes, a monitor pops and compares.
module cfgwin_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]        wdata = '0;
    logic [7:0]        rdata;
    logic              strap_alt = 1'b0, irq_pri = 1'b0, irq_sec = 1'b0;
    logic              sec_chan_en, fast_devsel;
    logic [3:0]        ra_disable;
    logic [7:0]        burst_sel;
    logic [47:0]       timing_bytes;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic rd_seen = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgwin_port u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .strap_alt(strap_alt),
        .irq_pri(irq_pri), .irq_sec(irq_sec), .sec_chan_en(sec_chan_en),
        .fast_devsel(fast_devsel), .ra_disable(ra_disable),
        .burst_sel(burst_sel), .timing_bytes(timing_bytes)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Monitor: note reads at the edge, compare half a cycle later.
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R11 unexpected read actual=%0h expected=none", rdata);
            end else begin
                check(tag_q.pop_front(), {56'd0, rdata}, {56'd0, exp_q.pop_front()});
            end
        end
    end

    localparam logic [ADDR_W-1:0] IDX0 = 10'h178, DAT0 = 10'h17C;
    localparam logic [ADDR_W-1:0] IDX1 = 10'h078, DAT1 = 10'h07C;

    task automatic sel(input logic [7:0] ix);
        bus_wr(IDX0, ix);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check("R4 reset sec_chan_en", sec_chan_en, 0);
        check("R5 reset fast_devsel", fast_devsel, 0);
        check("R4 reset ra_disable", ra_disable, 0);
        check("R7 reset burst_sel", burst_sel, 8'h40);
        check("R9 reset timing", timing_bytes, 0);
        bus_rd(IDX0, 8'h00, "R2 reset index");
        // Configuration byte
        sel(8'h50);
        bus_rd(DAT0, 8'h0A, "R3 cfg reset");
        irq_pri = 1'b1;
        bus_rd(DAT0, 8'h0E, "R3 cfg irq_pri");
        bus_wr(DAT0, 8'hFF);
        bus_rd(DAT0, 8'hCE, "R3 cfg write only top bits");
        bus_rd(IDX0, 8'h50, "R2 index readback");
        // Control byte
        sel(8'h51);
        bus_wr(DAT0, 8'h48);
        check("R4 sec_chan_en set", sec_chan_en, 1);
        check("R4 ra_disable drive0", ra_disable, 4'b0001);
        check("R5 devsel partial", fast_devsel, 0);
        bus_rd(DAT0, 8'h48, "R4 ctrl readback");
        bus_wr(DAT0, 8'hA7);
        check("R5 devsel all set", fast_devsel, 1);
        check("R4 ra_disable drive1", ra_disable, 4'b0010);
        check("R4 sec_chan_en clear", sec_chan_en, 0);
        bus_wr(DAT0, 8'h07);
        check("R5 devsel bit5 missing", fast_devsel, 0);
        // Secondary timing/status byte: write while interrupt active
        sel(8'h57);
        irq_sec = 1'b1;
        bus_wr(DAT0, 8'hFF);
        irq_sec = 1'b0;
        bus_rd(DAT0, 8'hEF, "R6 irq bit not stored");
        check("R6 ra_disable drives 2,3", ra_disable[3:2], 2'b11);
        irq_sec = 1'b1;
        bus_rd(DAT0, 8'hFF, "R6 irq bit live");
        irq_sec = 1'b0;
        // Burst and scratch
        sel(8'h59);
        bus_wr(DAT0, 8'h80);
        check("R7 burst_sel written", burst_sel, 8'h80);
        bus_rd(DAT0, 8'h80, "R7 burst readback");
        sel(8'h5B);
        bus_wr(DAT0, 8'hBD);
        bus_rd(DAT0, 8'hBD, "R8 scratch pattern");
        bus_wr(DAT0, 8'h00);
        bus_rd(DAT0, 8'h00, "R8 scratch cleared");
        // Timing bytes
        for (int s = 0; s < 6; s++) begin
            logic [7:0] ix;
            logic [7:0] v;
            ix = (s < 5) ? 8'h52 + 8'(s) : 8'h58;
            v  = 8'h11 * 8'(s + 1);
            sel(ix);
            bus_wr(DAT0, v);
            check("R9 timing slot on bus", timing_bytes[s*8 +: 8], v);
            bus_rd(DAT0, v, "R9 timing readback");
        end
        // Holes
        sel(8'h5A);
        bus_wr(DAT0, 8'h55);
        bus_rd(DAT0, 8'h00, "R10 hole 0x5A");
        sel(8'h00);
        bus_rd(DAT0, 8'h00, "R10 hole 0x00");
        check("R10 no side effect", {burst_sel, timing_bytes}, {8'h80, 48'h665544332211});
        // Hold behaviour
        sel(8'h5B);
        bus_wr(DAT0, 8'h3C);
        bus_rd(DAT0, 8'h3C, "R11 read scratch");
        bus_wr(DAT0, 8'h99);
        repeat (3) @(negedge clk);
        check("R11 rdata held", rdata, 8'h3C);
        // Base decoding
        bus_wr(DAT1, 8'h33);
        bus_rd(DAT0, 8'h99, "R1 alt data ignored while strap=0");
        bus_rd(DAT1, 8'h00, "R1 alt address reads zero");
        strap_alt = 1'b1;
        bus_rd(IDX1, 8'h5B, "R1 index at low base");
        bus_wr(DAT1, 8'h66);
        bus_rd(DAT1, 8'h66, "R1 data at low base");
        bus_rd(DAT0, 8'h00, "R1 high base dead when strap=1");
        bus_wr(IDX1, 8'h50);
        bus_rd(DAT1, 8'hEE, "R3 strap bit set");
        @(negedge clk);
        check("R11 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule